// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs a 16-step successive-approximation search for an external converter. A request pulse arrives on `conv_req`, and the conversion starts when that pulse falls. The block then presents a trial word to the feedback DAC. It samples a one-bit keep/reject decision from the comparator once per bit period. The final word stays on the same bus as the parallel result. While it works it raises `busy` and drives a gated bit clock `bit_clk`. That clock gives exactly seventeen pulses per conversion and sits low at all other times.

The word is negative-true. A cleared bit means the bit is switched on in the DAC, so the trial DAC code is the bitwise inverse of `word`. As a result, unipolar inputs read back as complementary straight binary and bipolar inputs as complementary offset binary. A second output, `alt_word`, gives the complementary two's complement form in bipolar mode by inverting the top bit.

Each bit period lasts `PERIOD` system clocks. The default is sized so that seventeen periods fit inside 14 µs at a 250 MHz system clock.

Top module: `sar_sequencer`

## Requirements
- R1: After synchronous reset, `busy` = 0, `bit_clk` = 0 and `word` = all ones (16'hFFFF).
- R2: A conversion starts only when `conv_req` goes from 1 to 0. Holding `conv_req` high does not start one. `busy` reads 1 from the first clock edge after the 1-to-0 transition is seen.
- R3: At the start edge, `word` is loaded with the top bit cleared and all lower bits set (16'h7FFF).
- R4: At the end of each bit period k (k = 0..15), bit position 15-k is set to 1 if `cmp_keep` = 0 (reject) and left at 0 if `cmp_keep` = 1 (keep). In the same step bit position 14-k is cleared. With a comparator that keeps when the inverted word is not above the input code, the final `word` equals the inverted input code. For example, a zero input gives 16'hBFFF after the first period.
- R5: `bit_clk` gives exactly 17 pulses per conversion. Each pulse is high for PERIOD/2 system clocks and a new pulse starts every PERIOD clocks. `bit_clk` is never high while `busy` is 0.
- R6: `word` changes only on clock edges where `bit_clk` rises, apart from reset. On the edge where `busy` falls, `word` does not change.
- R7: `busy` stays high for exactly 17·PERIOD system clocks per conversion.
- R8: A falling edge on `conv_req` while `busy` is 1 is ignored. This includes the edge on which `busy` clears. The result, the pulse count and the busy length are unchanged, and no new conversion follows.
- R9: `alt_word` equals `word` when `bipolar` = 0. It equals `word` with bit 15 inverted when `bipolar` = 1.
- R10: A reset in the middle of a conversion aborts it and gives the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_req | input | 1 | Conversion request; conversion starts on its falling edge |
| cmp_keep | input | 1 | Comparator decision: 1 keeps the current trial bit |
| bipolar | input | 1 | Range mode: 1 selects bipolar coding on `alt_word` |
| word | output | 16 | Negative-true trial word to the DAC and final result |
| alt_word | output | 16 | Result in two's complement form when bipolar, else same as `word` |
| busy | output | 1 | High while a conversion is in progress |
| bit_clk | output | 1 | Gated bit clock, 17 pulses per conversion, low when idle |

## Verification
Two functions can meet on one clock edge: a new request falling edge, and the end of a running conversion where `busy` clears. The bench lowers `conv_req` so that its fall is seen exactly 17·PERIOD edges after the accepted start. It then requires that `busy` stays low afterwards, that the result matches the inverted target code, and that only 17 bit clock pulses occurred. A second case sends a full request pulse in the middle of a conversion and expects results identical to an undisturbed run.

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int NBITS  = 16,
  parameter int PERIOD = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_req,
  input  logic             cmp_keep,
  input  logic             bipolar,
  output logic [NBITS-1:0] word,
  output logic [NBITS-1:0] alt_word,
  output logic             busy,
  output logic             bit_clk
);
  localparam int HALF = PERIOD / 2;
  localparam int CW   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int IW   = $clog2(NBITS + 1);
  localparam logic [NBITS-1:0] INIT_WORD = {1'b0, {(NBITS-1){1'b1}}};
  localparam logic [NBITS-1:0] TOP_BIT   = {1'b1, {(NBITS-1){1'b0}}};

  logic          conv_q;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [NBITS-1:0] trial_mask, next_mask;

  wire start_edge = conv_q & ~conv_req & ~busy;
  wire period_end = busy && (cnt == CW'(PERIOD - 1));
  wire last_period = (idx == IW'(NBITS));

  assign trial_mask = TOP_BIT >> idx;
  assign next_mask  = trial_mask >> 1;
  assign alt_word   = bipolar ? {~word[NBITS-1], word[NBITS-2:0]} : word;

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_q  <= 1'b0;
      busy    <= 1'b0;
      bit_clk <= 1'b0;
      word    <= '1;
      cnt     <= '0;
      idx     <= '0;
    end else begin
      conv_q <= conv_req;
      if (start_edge) begin
        busy    <= 1'b1;
        bit_clk <= 1'b1;
        word    <= INIT_WORD;
        cnt     <= '0;
        idx     <= '0;
      end else if (period_end) begin
        cnt <= '0;
        if (last_period) begin
          busy    <= 1'b0;
          bit_clk <= 1'b0;
        end else begin
          idx     <= idx + 1'b1;
          bit_clk <= 1'b1;
          word    <= (word | (cmp_keep ? '0 : trial_mask)) & ~next_mask;
        end
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(HALF - 1)) bit_clk <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
  parameter int NBITS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [NBITS-1:0] word,
  input logic             busy,
  input logic             bit_clk
);
  a_r5_idle_clk_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bit_clk);

  a_r3_init_word: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (word == {1'b0, {(NBITS-1){1'b1}}}));

  a_r5_first_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> bit_clk);

  a_r6_change_on_clk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(word)) |-> $rose(bit_clk));

  a_r6_data_before_status: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(busy)) |-> $stable(word));
endmodule

bind sar_sequencer sar_sequencer_chk #(.NBITS(NBITS)) chk_i (
  .clk(clk), .rst(rst), .word(word), .busy(busy), .bit_clk(bit_clk)
);

// File: tb/sar_sequencer_tb.sv
`timescale 1ns/1ps
module sar_sequencer_tb_top;
  localparam int P    = 8;
  localparam int HALF = P / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_req = 1'b0;
  logic bipolar = 1'b0;
  logic [15:0] target = 16'h0000;
  logic [15:0] word, alt_word;
  logic busy, bit_clk, cmp_keep;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  assign cmp_keep = ((~word) <= target);

  sar_sequencer #(.NBITS(16), .PERIOD(P)) dut_i (
    .clk(clk), .rst(rst), .conv_req(conv_req), .cmp_keep(cmp_keep),
    .bipolar(bipolar), .word(word), .alt_word(alt_word),
    .busy(busy), .bit_clk(bit_clk)
  );

  int rises, hi_run, bad_hi, busy_cyc, idle_hi, bad_chg, bad_end;
  logic p_clk, p_busy;
  logic [15:0] p_word;

  task automatic clr_mon();
    rises = 0; bad_hi = 0; busy_cyc = 0; idle_hi = 0; bad_chg = 0; bad_end = 0;
  endtask

  always @(negedge clk) begin
    if (rst) begin
      p_clk = bit_clk; p_busy = busy; p_word = word; hi_run = 0;
    end else begin
      if (bit_clk && !p_clk) rises++;
      if (bit_clk) hi_run++;
      else if (p_clk) begin
        if (hi_run != HALF) bad_hi++;
        hi_run = 0;
      end
      if (busy) busy_cyc++;
      if (bit_clk && !busy) idle_hi++;
      if (word !== p_word && !(bit_clk && !p_clk)) bad_chg++;
      if (p_busy && !busy && word !== p_word) bad_end++;
      p_clk = bit_clk; p_busy = busy; p_word = word;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) conv_req = 1'b1;
    @(negedge clk) conv_req = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20 * P && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic judge(input logic [15:0] t);
    chk(word == ~t, "R4 final word", word, ~t);
    chk(rises == 17, "R5 pulse count", rises, 17);
    chk(bad_hi == 0 && idle_hi == 0, "R5 pulse shape/idle low", bad_hi + idle_hi, 0);
    chk(busy_cyc == 17 * P, "R7 busy length", busy_cyc, 17 * P);
    chk(bad_chg == 0 && bad_end == 0, "R6 data timing", bad_chg + bad_end, 0);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(bit_clk == 1'b0, "R1 bit_clk", bit_clk, 0);
    chk(word == 16'hFFFF, "R1 word", word, 16'hFFFF);
  endtask

  task automatic t_start_edge();
    target = 16'h0000;
    clr_mon();
    @(negedge clk) conv_req = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R2 no start on level", busy, 0);
    conv_req = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R2 start on fall", busy, 1);
    chk(word == 16'h7FFF, "R3 init word", word, 16'h7FFF);
    repeat (P) @(negedge clk);
    chk(word == 16'hBFFF, "R4 first decision", word, 16'hBFFF);
    wait_done();
    judge(16'h0000);
  endtask

  task automatic t_conv(input logic [15:0] t);
    target = t;
    clr_mon();
    pulse_start();
    @(negedge clk);
    wait_done();
    judge(t);
  endtask

  task automatic t_mode();
    target = 16'h9885;
    clr_mon();
    pulse_start();
    @(negedge clk);
    wait_done();
    judge(16'h9885);
    chk(word == 16'b0110011101111010, "R4 pattern word", word, 16'b0110011101111010);
    bipolar = 1'b0;
    #1 chk(alt_word == word, "R9 unipolar alt", alt_word, word);
    bipolar = 1'b1;
    #1 chk(alt_word == (16'h677A ^ 16'h8000), "R9 bipolar alt", alt_word, 16'hE77A);
    bipolar = 1'b0;
  endtask

  task automatic t_mid_pulse();
    target = 16'h1234;
    clr_mon();
    pulse_start();
    repeat (40) @(negedge clk);
    conv_req = 1'b1;
    @(negedge clk) conv_req = 1'b0;
    wait_done();
    judge(16'h1234);
    chk(busy == 1'b0, "R8 no restart after mid pulse", busy, 0);
  endtask

  task automatic t_end_collide();
    target = 16'hA5C3;
    clr_mon();
    pulse_start();
    repeat (17 * P - 1) @(negedge clk);
    conv_req = 1'b1;
    @(negedge clk) conv_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R8 fall on end edge ignored", busy, 0);
    repeat (2 * P) @(negedge clk);
    judge(16'hA5C3);
    chk(busy == 1'b0, "R8 still idle", busy, 0);
  endtask

  task automatic t_abort();
    target = 16'h0F0F;
    pulse_start();
    repeat (30) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R10 abort busy", busy, 0);
    chk(word == 16'hFFFF, "R10 abort word", word, 16'hFFFF);
    chk(bit_clk == 1'b0, "R10 abort bit_clk", bit_clk, 0);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_start_edge();
    t_conv(16'hFFFF);
    t_conv(16'h8000);
    t_conv(16'h7FFF);
    t_mode();
    for (int i = 0; i < 4; i++) t_conv(16'($urandom()));
    t_mid_pulse();
    t_end_collide();
    t_abort();
    t_conv(16'h0001);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule